// File: doc/BRIEF.md
# Set-Associative Write-Back Tag Controller with True LRU

This block is the tag and state controller of a unified cache that holds instruction fetches and data accesses in one array. It is set-associative, writes modified lines back only when they leave the cache, and picks victims by exact least-recently-used order among the ways of a set. Total capacity, line size and number of ways are parameters. The block keeps no data payload. It tracks, for every line, a tag, a valid bit, a dirty bit and a recency rank.

Requests arrive one at a time on a valid/ready port. Each request carries a 2-bit source code, a 3-bit access code and a 32-bit byte address. Local reads, writes and fetches are looked up, and each one produces a single hit or miss response and bumps one of two counters. A miss drives line-aligned requests on a valid/ready memory port: first a writeback of a dirty victim when there is one, then a line fill. A flush code walks the whole array, writes back every dirty line and invalidates all lines. Remote requests, the all-zero idle pattern and unknown codes are taken and dropped.

Top module: `lru_wb_tag_ctrl`

## Requirements
- R1: After reset both counters read zero, `rsp_valid` and `mem_req_valid` are low, and `req_ready` stays low while every entry is cleared, then goes high.
- R2: A local request (`req_src`=1) with `req_type` 0 (read), 1 (write) or 2 (fetch) gives exactly one one-cycle `rsp_valid` pulse. `rsp_hit` is 1 when a valid line in the addressed set holds the tag, and exactly one of `hit_count` and `miss_count` grows by one.
- R3: A write hit marks the line dirty and causes no memory traffic. Read and fetch hits cause no memory traffic either.
- R4: On a miss the block issues a fill (`mem_req_write`=0) whose address is the request address with the offset bits cleared. When the victim is valid and dirty, a writeback (`mem_req_write`=1) with the victim's line address comes first. A write miss leaves the new line dirty.
- R5: The victim is the lowest-numbered invalid way of the set. When all ways are valid, it is the way used least recently, where a hit or a fill counts as a use.
- R6: A request with source, type and address all zero is accepted and changes nothing. It gives no response and no memory traffic, and `req_ready` stays high.
- R7: A request with a source other than 1, or a local request with type 5, 6 or 7, is accepted and dropped without touching any line, including a remote write to a resident line.
- R8: A local request with type 3 or 4 flushes the cache. Sets are visited in ascending order and, within a set, ways in ascending order. One writeback is issued per valid dirty line, all lines end invalid, `req_ready` is low until the walk ends, and there is no response and no counter change.
- R9: A memory request keeps its valid, address and write flag unchanged until `mem_req_ready` accepts it.
- R10: Data accesses may use any byte offset within a line, and fetches use word-aligned offsets. Every offset of a line maps to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_src | input | 2 | Source code: 1 local, 2 remote |
| req_type | input | 3 | Access code: 0 read, 1 write, 2 fetch, 3/4 flush |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | One-cycle completion of a local access |
| rsp_hit | output | 1 | Completed access hit |
| hit_count | output | 32 | Number of local hits |
| miss_count | output | 32 | Number of local misses |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 writeback, 0 line fill |
| mem_req_addr | output | 32 | Line-aligned memory address |

## Verification
Directed sequences fill one set past its way count. A write hit followed by an eviction shows whether the dirty bit and the LRU victim are right, and whether the writeback comes before the fill. Remote writes, the idle pattern and unknown codes are sent to resident lines, then a flush follows. The flush's writeback list shows whether any dropped request changed a dirty bit. Random traffic spreads a handful of tags over a few sets with random byte offsets, mixed request kinds and a memory that stalls at random. A bench model that orders lines by last-use time predicts every hit flag and memory request, which separates rank-based LRU errors from wrong victim choice among invalid ways.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;

  localparam int SRC_W  = 2;
  localparam int TYPE_W = 3;

  localparam logic [SRC_W-1:0]  SRC_LOCAL  = 2'd1;

  localparam logic [TYPE_W-1:0] ACC_READ   = 3'd0;
  localparam logic [TYPE_W-1:0] ACC_WRITE  = 3'd1;
  localparam logic [TYPE_W-1:0] ACC_FETCH  = 3'd2;
  localparam logic [TYPE_W-1:0] ACC_FLSH_A = 3'd3;
  localparam logic [TYPE_W-1:0] ACC_FLSH_B = 3'd4;

  typedef enum logic [2:0] {
    ST_WALK    = 3'd0,
    ST_WALK_WB = 3'd1,
    ST_IDLE    = 3'd2,
    ST_LOOK    = 3'd3,
    ST_WB      = 3'd4,
    ST_FILL    = 3'd5
  } ctrl_state_t;

endpackage

// File: rtl/tag_way_ram.sv
module tag_way_ram #(
  parameter int SETS  = 64,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic             wvalid,
  input  logic             wdirty,
  input  logic [TAG_W-1:0] wtag,
  output logic             rvalid,
  output logic             rdirty,
  output logic [TAG_W-1:0] rtag
);

  localparam int ENT_W = TAG_W + 2;

  logic [ENT_W-1:0] mem_q [SETS];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= {wvalid, wdirty, wtag};
  end

  assign {rvalid, rdirty, rtag} = mem_q[addr];

endmodule

// File: rtl/lru_rank_update.sv
module lru_rank_update #(
  parameter int WAYS  = 4,
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS*AGE_W-1:0] ages_in,
  input  logic [AGE_W-1:0]      way,
  output logic [WAYS*AGE_W-1:0] ages_out
);

  logic [AGE_W-1:0] used_age;
  assign used_age = ages_in[way*AGE_W +: AGE_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_rank
    logic [AGE_W-1:0] cur;
    assign cur = ages_in[g*AGE_W +: AGE_W];
    always_comb begin
      if (way == AGE_W'(g))      ages_out[g*AGE_W +: AGE_W] = '0;
      else if (cur < used_age)   ages_out[g*AGE_W +: AGE_W] = cur + AGE_W'(1);
      else                       ages_out[g*AGE_W +: AGE_W] = cur;
    end
  end

endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS  = 4,
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid_vec,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic [AGE_W-1:0]      victim
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_vec[i]) begin
        victim = AGE_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (ages[i*AGE_W +: AGE_W] == OLDEST) victim = AGE_W'(i);
      end
    end
  end

endmodule

// File: rtl/lru_wb_tag_ctrl.sv
module lru_wb_tag_ctrl
  import lru_cache_pkg::*;
#(
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 32,
  parameter int WAYS        = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr
);

  localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int AGE_W = $clog2(WAYS);
  localparam int RANK_W = WAYS * AGE_W;
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);
  localparam logic [AGE_W-1:0] LAST_WAY = AGE_W'(WAYS - 1);

  // ---------------- registers ----------------
  ctrl_state_t       st_q;
  logic              ready_q, rsp_v_q, rsp_h_q;
  logic [CNT_W-1:0]  hit_q, miss_q;
  logic              mem_v_q, mem_w_q;
  logic [ADDR_W-1:0] mem_a_q;
  logic [TAG_W-1:0]  a_tag_q;
  logic [IDX_W-1:0]  a_idx_q;
  logic              a_wr_q;
  logic [IDX_W-1:0]  walk_set_q;
  logic [AGE_W-1:0]  walk_way_q;
  logic              walk_wb_q;
  logic [AGE_W-1:0]  vic_way_q;

  // ---------------- array access ----------------
  logic [IDX_W-1:0]  arr_idx;
  logic [WAYS-1:0]   way_we;
  logic              w_valid, w_dirty;
  logic [TAG_W-1:0]  w_tag;
  logic [WAYS-1:0]   rv, rd;
  logic [TAG_W-1:0]  rt [WAYS];

  logic              in_walk;
  assign in_walk = (st_q == ST_WALK) || (st_q == ST_WALK_WB);
  assign arr_idx = in_walk ? walk_set_q : a_idx_q;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tag_way_ram #(.SETS(SETS), .TAG_W(TAG_W)) ram_i (
      .clk    (clk),
      .we     (way_we[g]),
      .addr   (arr_idx),
      .wvalid (w_valid),
      .wdirty (w_dirty),
      .wtag   (w_tag),
      .rvalid (rv[g]),
      .rdirty (rd[g]),
      .rtag   (rt[g])
    );
  end

  // recency ranks, one packed word per set
  logic [RANK_W-1:0] rank_mem [SETS];
  logic [RANK_W-1:0] rank_rd, rank_upd, rank_init, rank_wdata;
  logic              rank_we;

  assign rank_rd = rank_mem[arr_idx];

  for (genvar g = 0; g < WAYS; g++) begin : g_init
    assign rank_init[g*AGE_W +: AGE_W] = AGE_W'(g);
  end

  always_ff @(posedge clk) begin
    if (rank_we) rank_mem[arr_idx] <= rank_wdata;
  end

  // ---------------- lookup ----------------
  logic [WAYS-1:0]  hit_vec;
  logic             hit_any;
  logic [AGE_W-1:0] hit_way, vic_way, upd_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = rv[g] && (rt[g] == a_tag_q);
  end
  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = AGE_W'(i);
    end
  end

  victim_pick #(.WAYS(WAYS)) pick_i (
    .valid_vec (rv),
    .ages      (rank_rd),
    .victim    (vic_way)
  );

  assign upd_way = (st_q == ST_LOOK) ? hit_way : vic_way_q;

  lru_rank_update #(.WAYS(WAYS)) rank_i (
    .ages_in  (rank_rd),
    .way      (upd_way),
    .ages_out (rank_upd)
  );

  // ---------------- walk helpers ----------------
  logic cur_v, cur_d, need_wb, walk_step, walk_done;
  logic [TAG_W-1:0] cur_t;
  assign cur_v   = rv[walk_way_q];
  assign cur_d   = rd[walk_way_q];
  assign cur_t   = rt[walk_way_q];
  assign need_wb = walk_wb_q && cur_v && cur_d;
  assign walk_step = ((st_q == ST_WALK) && !need_wb) ||
                     ((st_q == ST_WALK_WB) && mem_req_ready);
  assign walk_done = walk_step && (walk_way_q == LAST_WAY) && (walk_set_q == LAST_SET);

  // ---------------- array write control ----------------
  always_comb begin
    way_we     = '0;
    w_valid    = 1'b0;
    w_dirty    = 1'b0;
    w_tag      = a_tag_q;
    rank_we    = 1'b0;
    rank_wdata = rank_upd;
    unique case (st_q)
      ST_WALK, ST_WALK_WB: begin
        if (walk_step) begin
          way_we[walk_way_q] = 1'b1;
          if (walk_way_q == LAST_WAY) begin
            rank_we    = 1'b1;
            rank_wdata = rank_init;
          end
        end
      end
      ST_LOOK: begin
        if (hit_any) begin
          rank_we = 1'b1;
          if (a_wr_q) begin
            way_we[hit_way] = 1'b1;
            w_valid = 1'b1;
            w_dirty = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (mem_req_ready) begin
          way_we[vic_way_q] = 1'b1;
          w_valid = 1'b1;
          w_dirty = a_wr_q;
          rank_we = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // ---------------- request decode ----------------
  logic take, is_local, is_access, is_flush;
  assign take      = (st_q == ST_IDLE) && ready_q && req_valid;
  assign is_local  = (req_src == SRC_LOCAL);
  assign is_access = (req_type == ACC_READ) || (req_type == ACC_WRITE) ||
                     (req_type == ACC_FETCH);
  assign is_flush  = (req_type == ACC_FLSH_A) || (req_type == ACC_FLSH_B);

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_WALK;
      ready_q    <= 1'b0;
      rsp_v_q    <= 1'b0;
      rsp_h_q    <= 1'b0;
      hit_q      <= '0;
      miss_q     <= '0;
      mem_v_q    <= 1'b0;
      mem_w_q    <= 1'b0;
      mem_a_q    <= '0;
      a_tag_q    <= '0;
      a_idx_q    <= '0;
      a_wr_q     <= 1'b0;
      walk_set_q <= '0;
      walk_way_q <= '0;
      walk_wb_q  <= 1'b0;
      vic_way_q  <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_WALK: begin
          if (need_wb) begin
            mem_v_q <= 1'b1;
            mem_w_q <= 1'b1;
            mem_a_q <= {cur_t, walk_set_q, {OFF_W{1'b0}}};
            st_q    <= ST_WALK_WB;
          end
        end
        ST_WALK_WB: begin
          if (mem_req_ready) begin
            mem_v_q <= 1'b0;
            st_q    <= ST_WALK;
          end
        end
        ST_IDLE: begin
          if (take && is_local && is_access) begin
            a_tag_q <= req_addr[ADDR_W-1 -: TAG_W];
            a_idx_q <= req_addr[OFF_W +: IDX_W];
            a_wr_q  <= (req_type == ACC_WRITE);
            ready_q <= 1'b0;
            st_q    <= ST_LOOK;
          end else if (take && is_local && is_flush) begin
            walk_wb_q  <= 1'b1;
            walk_set_q <= '0;
            walk_way_q <= '0;
            ready_q    <= 1'b0;
            st_q       <= ST_WALK;
          end
        end
        ST_LOOK: begin
          if (hit_any) begin
            hit_q   <= hit_q + CNT_W'(1);
            rsp_v_q <= 1'b1;
            rsp_h_q <= 1'b1;
            ready_q <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            miss_q    <= miss_q + CNT_W'(1);
            vic_way_q <= vic_way;
            mem_v_q   <= 1'b1;
            if (rv[vic_way] && rd[vic_way]) begin
              mem_w_q <= 1'b1;
              mem_a_q <= {rt[vic_way], a_idx_q, {OFF_W{1'b0}}};
              st_q    <= ST_WB;
            end else begin
              mem_w_q <= 1'b0;
              mem_a_q <= {a_tag_q, a_idx_q, {OFF_W{1'b0}}};
              st_q    <= ST_FILL;
            end
          end
        end
        ST_WB: begin
          if (mem_req_ready) begin
            mem_w_q <= 1'b0;
            mem_a_q <= {a_tag_q, a_idx_q, {OFF_W{1'b0}}};
            st_q    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_req_ready) begin
            mem_v_q <= 1'b0;
            rsp_v_q <= 1'b1;
            rsp_h_q <= 1'b0;
            ready_q <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      if (walk_step) begin
        if (walk_done) begin
          walk_way_q <= '0;
          walk_set_q <= '0;
          walk_wb_q  <= 1'b0;
          ready_q    <= 1'b1;
          st_q       <= ST_IDLE;
        end else if (walk_way_q == LAST_WAY) begin
          walk_way_q <= '0;
          walk_set_q <= walk_set_q + IDX_W'(1);
        end else begin
          walk_way_q <= walk_way_q + AGE_W'(1);
        end
      end
    end
  end

  assign req_ready     = ready_q;
  assign rsp_valid     = rsp_v_q;
  assign rsp_hit       = rsp_h_q;
  assign hit_count     = hit_q;
  assign miss_count    = miss_q;
  assign mem_req_valid = mem_v_q;
  assign mem_req_write = mem_w_q;
  assign mem_req_addr  = mem_a_q;

  // ---------------- assertions ----------------
  // R9: a pending memory request does not move until accepted
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R2: a response lasts a single cycle
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2: at most one valid line per set holds a given tag
  p_hit_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOOK) |-> $onehot0(hit_vec));

  // R2: counters move only when a lookup resolves
  p_count_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_LOOK) |=> $stable(hit_count) && $stable(miss_count));

  // R8: the flush walk blocks new requests and gives no response
  p_walk_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    in_walk |-> !req_ready && !rsp_valid);

  // R4: no new request is taken while memory traffic is outstanding
  p_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

endmodule

// File: tb/lru_wb_tag_ctrl_tb.sv
module lru_wb_tag_ctrl_tb_top;

  localparam int CACHE_BYTES = 8192;
  localparam int LINE_BYTES  = 32;
  localparam int WAYS        = 4;
  localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_src = '0;
  logic [2:0]  req_type = '0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] hit_count, miss_count;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;

  always #2 clk = ~clk;

  lru_wb_tag_ctrl #(
    .CACHE_BYTES(CACHE_BYTES), .LINE_BYTES(LINE_BYTES), .WAYS(WAYS)
  ) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_type(req_type), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .hit_count(hit_count), .miss_count(miss_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int  m_tag [SETS][WAYS];
  bit  m_v   [SETS][WAYS];
  bit  m_d   [SETS][WAYS];
  int  m_use [SETS][WAYS];
  int  m_time = 0;
  int  exp_hits = 0, exp_miss = 0;
  int  exp_addr [SETS*WAYS];
  bit  exp_wr   [SETS*WAYS];
  int  exp_n;
  bit  exp_hit;

  function automatic int line_of(input int tag, input int set);
    return (tag << (OFF_W + IDX_W)) | (set << OFF_W);
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_use[s][w] = 0; m_tag[s][w] = 0;
      end
  endfunction

  function automatic void model_access(input int typ, input logic [31:0] addr);
    int set, tag, way, oldest;
    set = int'((addr >> OFF_W) % SETS);
    tag = int'(addr >> (OFF_W + IDX_W));
    exp_n = 0;
    m_time++;
    way = -1;
    for (int w = 0; w < WAYS; w++) if (m_v[set][w] && m_tag[set][w] == tag) way = w;
    if (way >= 0) begin
      exp_hit = 1; exp_hits++;
      m_use[set][way] = m_time;
      if (typ == 1) m_d[set][way] = 1;
      return;
    end
    exp_hit = 0; exp_miss++;
    for (int w = WAYS - 1; w >= 0; w--) if (!m_v[set][w]) way = w;
    if (way < 0) begin
      oldest = 32'h7fffffff;
      for (int w = 0; w < WAYS; w++)
        if (m_use[set][w] < oldest) begin oldest = m_use[set][w]; way = w; end
      if (m_d[set][way]) begin
        exp_addr[exp_n] = line_of(m_tag[set][way], set); exp_wr[exp_n] = 1; exp_n++;
      end
    end
    exp_addr[exp_n] = int'(addr & ~32'(LINE_BYTES - 1)); exp_wr[exp_n] = 0; exp_n++;
    m_v[set][way] = 1; m_d[set][way] = (typ == 1); m_tag[set][way] = tag;
    m_use[set][way] = m_time;
  endfunction

  function automatic void model_flush();
    exp_n = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (m_v[s][w] && m_d[s][w]) begin
          exp_addr[exp_n] = line_of(m_tag[s][w], s); exp_wr[exp_n] = 1; exp_n++;
        end
    model_clear();
  endfunction

  // ---------------- memory responder ----------------
  int   obs_addr [SETS*WAYS + 4];
  bit   obs_wr   [SETS*WAYS + 4];
  int   obs_n = 0;
  int   rsp_seen = 0;
  int   ready_pct = 70;
  bit   prev_pend = 0;
  logic [31:0] prev_addr = '0;
  bit   prev_wr = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        bit r;
        if (rsp_valid) rsp_seen++;
        if (prev_pend) begin
          check(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_wr,
                "R9 hold", longint'(mem_req_addr), longint'(prev_addr));
        end
        r = ($urandom_range(0, 99) < ready_pct);
        mem_req_ready = r;
        if (mem_req_valid && r) begin
          if (obs_n < SETS*WAYS + 4) begin
            obs_addr[obs_n] = int'(mem_req_addr); obs_wr[obs_n] = mem_req_write;
          end
          obs_n++;
        end
        prev_pend = mem_req_valid && !r;
        prev_addr = mem_req_addr;
        prev_wr   = mem_req_write;
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic finish_bench();
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!req_ready) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        check(0, {req, " ready timeout"}, 0, 1);
        finish_bench();
      end
    end
  endtask

  task automatic send(input logic [1:0] src, input logic [2:0] typ, input logic [31:0] addr);
    wait_ready("R2");
    obs_n = 0;
    req_src = src; req_type = typ; req_addr = addr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    check(obs_n == exp_n, {req, " memory request count"}, obs_n, exp_n);
    for (int k = 0; k < exp_n && k < obs_n; k++) begin
      check(obs_addr[k] == exp_addr[k], {req, " memory address"}, obs_addr[k], exp_addr[k]);
      check(obs_wr[k] == exp_wr[k], {req, " memory write flag"}, obs_wr[k], exp_wr[k]);
    end
  endtask

  task automatic access(input int typ, input logic [31:0] addr, input string req);
    int n = 0;
    model_access(typ, addr);
    send(2'd1, 3'(typ), addr);
    while (!rsp_valid) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        check(0, {req, " response timeout"}, 0, 1);
        finish_bench();
      end
    end
    check(rsp_hit == exp_hit, {req, " hit flag"}, rsp_hit, exp_hit);
    compare_mem(req);
    check(hit_count == 32'(exp_hits) && miss_count == 32'(exp_miss), "R2 counters",
          {hit_count, miss_count}, {32'(exp_hits), 32'(exp_miss)});
  endtask

  task automatic flush(input int typ);
    int h0, m0, r0;
    h0 = int'(hit_count); m0 = int'(miss_count);
    model_flush();
    send(2'd1, 3'(typ), 32'h0000_1234);
    r0 = rsp_seen;
    check(req_ready == 1'b0, "R8 ready low during walk", req_ready, 0);
    wait_ready("R8");
    compare_mem("R8");
    check(rsp_seen == r0, "R8 no response", rsp_seen, r0);
    check(int'(hit_count) == h0 && int'(miss_count) == m0, "R8 counters unchanged",
          hit_count, h0);
  endtask

  task automatic ignored(input logic [1:0] src, input logic [2:0] typ,
                         input logic [31:0] addr, input string req);
    int r0;
    r0 = rsp_seen;
    send(src, typ, addr);
    check(req_ready == 1'b1, {req, " ready stays high"}, req_ready, 1);
    repeat (4) @(negedge clk);
    check(obs_n == 0 && rsp_seen == r0, {req, " no traffic or response"}, obs_n, 0);
  endtask

  function automatic logic [31:0] mk_addr(input int tag, input int set, input int off);
    return 32'(line_of(tag, set) | off);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_bench();
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b0, "R1 ready low while clearing", req_ready, 0);
    check(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count, 0);
    check(rsp_valid == 0 && mem_req_valid == 0, "R1 outputs idle", {rsp_valid, mem_req_valid}, 0);
    wait_ready("R1");
    check(req_ready == 1'b1, "R1 ready after clearing", req_ready, 1);

    // R4 cold miss, R10 byte offsets within one line
    access(0, mk_addr(3, 5, 7), "R4 cold read miss");
    access(0, mk_addr(3, 5, 31), "R10 other byte same line");
    access(2, mk_addr(3, 5, 4), "R10 word fetch same line");
    // R3 write hit sets dirty
    access(1, mk_addr(3, 5, 1), "R3 write hit");
    // R5 fill rest of set, then evict least recently used
    access(0, mk_addr(4, 5, 0), "R5 fill way 1");
    access(1, mk_addr(5, 5, 9), "R4 write miss allocate");
    access(0, mk_addr(6, 5, 0), "R5 fill way 3");
    access(0, mk_addr(7, 5, 0), "R5 evict dirty LRU with writeback");
    access(0, mk_addr(4, 5, 2), "R5 hit on way 1");
    access(0, mk_addr(8, 5, 0), "R5 evict LRU after reuse");

    // R6 NOP, R7 remote and unknown codes
    access(0, mk_addr(6, 9, 0), "R4 clean line set 9");
    ignored(2'd0, 3'd0, 32'd0, "R6 nop");
    ignored(2'd2, 3'd1, mk_addr(6, 9, 0), "R7 remote write");
    ignored(2'd2, 3'd3, 32'd0, "R7 remote flush");
    ignored(2'd1, 3'd5, mk_addr(6, 9, 0), "R7 unknown type");
    ignored(2'd3, 3'd1, mk_addr(6, 9, 0), "R7 unknown source");
    access(0, mk_addr(6, 9, 8), "R7 line still resident");
    flush(3);
    access(0, mk_addr(6, 9, 8), "R8 line gone after flush");

    // random mix
    for (int i = 0; i < 700; i++) begin
      int pick, tag, set, off, typ;
      pick = $urandom_range(0, 99);
      tag = $urandom_range(0, 6);
      set = $urandom_range(0, 3) * 3;
      off = $urandom_range(0, LINE_BYTES - 1);
      if (i % 100 == 0) ready_pct = (i % 200 == 0) ? 100 : 40;
      if (pick < 84) begin
        typ = $urandom_range(0, 2);
        if (typ == 2) off = off & ~3;
        access(typ, mk_addr(tag, set, off), "R5 random access");
      end else if (pick < 91) begin
        ignored(2'd2, 3'($urandom_range(0, 4)), mk_addr(tag, set, off), "R7 random remote");
      end else if (pick < 98) begin
        ignored(2'd0, 3'd0, 32'd0, "R6 random nop");
      end else begin
        flush(3 + (i % 2));
      end
    end
    flush(4);
    finish_bench();
  end

endmodule